// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, side A and side B, with a non-inverting transfer path each way and one storage register per direction. The A-side register captures the A bus, the B-side register captures the B bus. Each capture is triggered by the rising edge of its own strobe. Both strobes are sampled in the system clock domain.

Each output path has a select. It chooses between the live value on the opposite bus and the register that holds that bus's stored value. A direction input and an active-low enable decide which side, if any, is driven. Tri-state pins are modelled as separate input, output and drive-enable vectors per side, so that a wrapper can map them onto real bidirectional pads.

Captures are never gated by the enable, the direction or the selects. The block can therefore store data while it is isolated, and it can store data in the middle of a transfer.

Top module: `xcvr_reg_bidir`

## Requirements
- R1: The A-side register loads `a_in` at the first rising clock edge at which `cap_a_stb` is sampled high while its sample from the previous clock was low. The new value is visible from that edge on.
- R2: The B-side register loads `b_in` under the same rule, using `cap_b_stb`.
- R3: A register keeps its value at every clock edge that is not a capture edge for it. This includes a strobe held high for many cycles, which produces only one capture.
- R4: A synchronous active-high `rst` clears both registers to zero. During reset each strobe history is set as if the strobe were already high, so a strobe held high through reset produces no capture when reset ends.
- R5: With `en_n` high, both `a_oe` and `b_oe` are all zeros, and captures on both sides still take place.
- R6: With `en_n` low and `dir_to_b` high, `b_oe` is all ones and `a_oe` is all zeros. With `en_n` low and `dir_to_b` low, `a_oe` is all ones and `b_oe` is all zeros. These outputs follow the inputs combinationally.
- R7: `b_out` equals `a_in` when `b_from_reg` is 0 and equals the A-side register when `b_from_reg` is 1, bit for bit and without inversion.
- R8: `a_out` equals `b_in` when `a_from_reg` is 0 and equals the B-side register when `a_from_reg` is 1, bit for bit and without inversion.
- R9: A capture occurs regardless of `en_n`, `dir_to_b` and the selects. While a stored value is selected onto a side, that side's output shows the newly captured value immediately after the capture edge.
- R10: `a_oe` and `b_oe` never have any bit set at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_a_stb | input | 1 | Capture strobe for the A-side register (rising edge) |
| cap_b_stb | input | 1 | Capture strobe for the B-side register (rising edge) |
| en_n | input | 1 | Active-low enable for all drivers |
| dir_to_b | input | 1 | 1: drive side B, 0: drive side A |
| b_from_reg | input | 1 | Source for B output: 0 live A bus, 1 A-side register |
| a_from_reg | input | 1 | Source for A output: 0 live B bus, 1 B-side register |
| a_in | input | DATA_W | Value seen on the A bus |
| b_in | input | DATA_W | Value seen on the B bus |
| a_out | output | DATA_W | Value offered to the A bus |
| a_oe | output | DATA_W | Per-bit drive enable for the A bus |
| b_out | output | DATA_W | Value offered to the B bus |
| b_oe | output | DATA_W | Per-bit drive enable for the B bus |

## Verification
The stored values can only be seen through the outputs with the register select set. A missed, doubled or early capture, or a register that leaks its value, therefore shows as a wrong `b_out` or `a_out` on the first cycle that selects the stored source after the faulty clock edge. Random traffic selects the stored source about half the time, which keeps that exposure short. A fault in the drive-enable decode shows in the same cycle as the `en_n` or `dir_to_b` change that triggers it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Index of each capture strobe in the strobe vector
  typedef enum int unsigned {
    SIDE_A = 0,
    SIDE_B = 1
  } side_e;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stb,
  output logic [N-1:0] rise
);
  logic [N-1:0] stb_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    // History is set to 1 during reset, so a strobe held high gives no edge afterwards
    always_ff @(posedge clk) begin
      if (rst) stb_q[i] <= 1'b1;
      else     stb_q[i] <= stb[i];
    end

    assign rise[i] = stb[i] & ~stb_q[i];

    // R3: one rising strobe cannot report an edge on two consecutive clocks
    p_single_edge_r3: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R1 / R2: a load edge stores the sampled data
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));

  // R3: without a load the value stays put
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R4: reset clears the register
  p_clear_r4: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int unsigned W = 8
) (
  input  logic         use_reg,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out
);
  // One independent, non-inverting channel per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out[i] = use_reg ? stored[i] : live[i];
  end
endmodule

// File: rtl/xcvr_reg_bidir.sv
module xcvr_reg_bidir #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_a_stb,
  input  logic              cap_b_stb,
  input  logic              en_n,
  input  logic              dir_to_b,
  input  logic              b_from_reg,
  input  logic              a_from_reg,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] a_oe,
  output logic [DATA_W-1:0] b_out,
  output logic [DATA_W-1:0] b_oe
);
  import xcvr_pkg::*;

  logic [NUM_SIDES-1:0] stb_vec;
  logic [NUM_SIDES-1:0] rise_vec;
  logic [DATA_W-1:0]    reg_a;
  logic [DATA_W-1:0]    reg_b;
  logic                 drive_a;
  logic                 drive_b;

  assign stb_vec[SIDE_A] = cap_a_stb;
  assign stb_vec[SIDE_B] = cap_b_stb;

  xcvr_edge #(.N(NUM_SIDES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .stb  (stb_vec),
    .rise (rise_vec)
  );

  xcvr_store #(.W(DATA_W)) u_store_a (
    .clk  (clk),
    .rst  (rst),
    .load (rise_vec[SIDE_A]),
    .d    (a_in),
    .q    (reg_a)
  );

  xcvr_store #(.W(DATA_W)) u_store_b (
    .clk  (clk),
    .rst  (rst),
    .load (rise_vec[SIDE_B]),
    .d    (b_in),
    .q    (reg_b)
  );

  xcvr_path #(.W(DATA_W)) u_path_b (
    .use_reg (b_from_reg),
    .live    (a_in),
    .stored  (reg_a),
    .out     (b_out)
  );

  xcvr_path #(.W(DATA_W)) u_path_a (
    .use_reg (a_from_reg),
    .live    (b_in),
    .stored  (reg_b),
    .out     (a_out)
  );

  always_comb begin
    drive_a = ~en_n & ~dir_to_b;
    drive_b = ~en_n &  dir_to_b;
  end

  assign a_oe = {DATA_W{drive_a}};
  assign b_oe = {DATA_W{drive_b}};

  // R10: never both sides driven
  p_one_side_r10: assert property (@(posedge clk) disable iff (rst)
    !((|a_oe) && (|b_oe)));

  // R5: isolation keeps both sides undriven
  p_isolate_r5: assert property (@(posedge clk) disable iff (rst)
    en_n |-> (a_oe == '0) && (b_oe == '0));

  // R9: the stored path shows a fresh capture on the next cycle
  p_follow_r9: assert property (@(posedge clk) disable iff (rst)
    (rise_vec[SIDE_A] && b_from_reg) ##1 b_from_reg |-> b_out == $past(a_in));
endmodule

// File: tb/xcvr_reg_bidir_bench.sv
module xcvr_reg_bidir_bench;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         cap_a_stb, cap_b_stb, en_n, dir_to_b, b_from_reg, a_from_reg;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  // bench model of the two registers and strobe history
  logic [W-1:0] m_ra, m_rb;
  logic         m_pa, m_pb;

  always #5 clk = ~clk;

  xcvr_reg_bidir #(.DATA_W(W)) u_xcvr_reg_bidir (
    .clk(clk), .rst(rst), .cap_a_stb(cap_a_stb), .cap_b_stb(cap_b_stb),
    .en_n(en_n), .dir_to_b(dir_to_b), .b_from_reg(b_from_reg),
    .a_from_reg(a_from_reg), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_b_out();
    return b_from_reg ? m_ra : a_in;
  endfunction

  function automatic logic [W-1:0] exp_a_out();
    return a_from_reg ? m_rb : b_in;
  endfunction

  function automatic logic [W-1:0] exp_b_oe();
    return {W{~en_n & dir_to_b}};
  endfunction

  function automatic logic [W-1:0] exp_a_oe();
    return {W{~en_n & ~dir_to_b}};
  endfunction

  // Compare every output with the model (called away from clock edges)
  task automatic check_all(input string tag);
    chk({tag, " R7 b_out"}, b_out, exp_b_out());
    chk({tag, " R8 a_out"}, a_out, exp_a_out());
    chk({tag, " R6 b_oe"},  b_oe,  exp_b_oe());
    chk({tag, " R6 a_oe"},  a_oe,  exp_a_oe());
    n_checks++;
    if ((|a_oe) && (|b_oe)) begin
      n_fail++;
      $display("FAIL R10: actual a_oe=%h b_oe=%h expected one side zero", a_oe, b_oe);
    end
  endtask

  // Advance one clock, updating the model with the inputs the bench holds
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      m_ra = '0; m_rb = '0; m_pa = 1'b1; m_pb = 1'b1;
    end else begin
      if (cap_a_stb && !m_pa) m_ra = a_in;
      if (cap_b_stb && !m_pb) m_rb = b_in;
      m_pa = cap_a_stb;
      m_pb = cap_b_stb;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; cap_a_stb = 1'b1; cap_b_stb = 1'b0; en_n = 1'b1; dir_to_b = 1'b0;
    b_from_reg = 1'b1; a_from_reg = 1'b1; a_in = 8'hA5; b_in = 8'h3C;
    m_ra = '0; m_rb = '0; m_pa = 1'b1; m_pb = 1'b1;
    @(negedge clk);
    tick(); tick();
    // R4: registers read zero after reset
    #1 check_all("R4 reset");
    chk("R4 reg_a zero", b_out, 8'h00);
    chk("R5 isolated a_oe", a_oe, 8'h00);

    // R4: strobe high through reset gives no capture
    rst = 1'b0;
    tick();
    #1 chk("R4 no phantom capture", b_out, 8'h00);

    // R1 + R5: capture while isolated; R3 held strobe does not reload
    cap_a_stb = 1'b0; tick();
    cap_a_stb = 1'b1; a_in = 8'h5A; tick();
    #1 chk("R1 capture isolated", b_out, 8'h5A);
    a_in = 8'hFF; tick(); tick();
    #1 chk("R3 held strobe", b_out, 8'h5A);

    // R2 + R9: capture B during a transfer onto A with stored source
    en_n = 1'b0; dir_to_b = 1'b0; b_in = 8'h81; cap_b_stb = 1'b1;
    #1 chk("R9 before capture", a_out, 8'h00);
    chk("R6 a driven", a_oe, 8'hFF);
    tick();
    #1 chk("R2 R9 follows capture", a_out, 8'h81);
    b_in = 8'h00; a_from_reg = 1'b0;
    #1 chk("R8 live path", a_out, 8'h00);
    dir_to_b = 1'b1;
    #1 chk("R6 b driven", b_oe, 8'hFF);
    chk("R6 a released", a_oe, 8'h00);
    cap_b_stb = 1'b0;
    tick();

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      rst        = ($urandom_range(0, 199) == 0);
      cap_a_stb  = $urandom_range(0, 1);
      cap_b_stb  = $urandom_range(0, 1);
      en_n       = $urandom_range(0, 1);
      dir_to_b   = $urandom_range(0, 1);
      b_from_reg = $urandom_range(0, 1);
      a_from_reg = $urandom_range(0, 1);
      a_in       = W'($urandom);
      b_in       = W'($urandom);
      #1 check_all("rand");
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule